// File: doc/BRIEF.md
# Accumulator ALU with condition codes

This block is the arithmetic and logic stage of a small 8-bit accumulator core. For each operation it takes the select code, the accumulator, an 8-bit operand, the current condition-code byte and the two 16-bit pointers (stack pointer and the H:X index pair). It returns the new accumulator value, both pointers and the new condition-code byte in the same cycle. The sequencer around it fetches operands and writes back results.

The operations are add with carry, add without carry, bitwise AND, shift left and sign-preserving shift right. There are also two pointer adjustments, each of which adds a sign-extended 8-bit immediate (taken from the operand input) to one 16-bit pointer. The flag rules follow the usual 8-bit accumulator conventions, including a half-carry out of the low nibble. The pointer adjustments leave every flag unchanged.

The condition-code output can be taken straight from the logic or through a register that the parameter `CCR_REG` selects.

Top module: `acc_alu`

## Requirements
- R1: With `op_i` = 0 (add with carry), `res_o` = `acc_i` + `opnd_i` + `ccr_i[0]`, taken modulo 256.
- R2: With `op_i` = 1 (add without carry), `res_o` = `acc_i` + `opnd_i` modulo 256, and the incoming carry has no effect.
- R3: For both adds, the half-carry flag `ccr_o[4]` is the carry out of bit 3 and the carry flag `ccr_o[0]` is the carry out of bit 7.
- R4: For both adds, the overflow flag `ccr_o[7]` is set exactly when the operands share a sign bit and the result's sign bit differs from it.
- R5: For operations 0 to 4, the negative flag `ccr_o[2]` equals `res_o[7]`, and the zero flag `ccr_o[1]` is set exactly when `res_o` is 0.
- R6: With `op_i` = 2, `res_o` = `acc_i` AND `opnd_i`, the overflow flag is cleared, and H and C keep their `ccr_i` values.
- R7: With `op_i` = 3 (shift left), `res_o` = {`acc_i[6:0]`, 0} and C takes `acc_i[7]`.
- R8: With `op_i` = 4 (shift right), `res_o` = {`acc_i[7]`, `acc_i[7:1]`} and C takes `acc_i[0]`.
- R9: For both shifts, the overflow flag equals N XOR C after the shift, and H keeps its `ccr_i` value.
- R10: With `op_i` = 5, `sp_o` = `sp_i` + the sign-extended `opnd_i`, modulo 65536, and `hx_o` = `hx_i`.
- R11: With `op_i` = 6, `hx_o` = `hx_i` + the sign-extended `opnd_i`, modulo 65536, and `sp_o` = `sp_i`.
- R12: For operations 5 and 6, `res_o` = `acc_i`, and bits 7 and 4 to 0 of `ccr_o` equal the same bits of `ccr_i`. For operations 0 to 4, both pointers pass through unchanged.
- R13: The interrupt-mask bit `ccr_o[3]` always equals `ccr_i[3]`, and bits 6 and 5 of `ccr_o` always read 1.
- R14: With `CCR_REG` = 1, `ccr_o` reads 8'h68 while in reset, and otherwise shows the flag result of the inputs that were present at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the optional flag register |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 3 | Operation select, values 0 to 6 |
| acc_i | input | 8 | Accumulator operand |
| opnd_i | input | 8 | Memory operand or signed immediate |
| ccr_i | input | 8 | Current condition-code byte |
| sp_i | input | 16 | Current stack pointer |
| hx_i | input | 16 | Current H:X index pair |
| res_o | output | 8 | New accumulator value |
| sp_o | output | 16 | New stack pointer |
| hx_o | output | 16 | New H:X index pair |
| ccr_o | output | 8 | New condition-code byte |

## Verification
On every clock cycle, the assertions check the flag relations that hold for any operands. These are the overflow rule for adds expressed as carry-in XOR carry-out of the sign bit, the zero flag against the result, V = N XOR C after shifts, the cleared V after AND, the fixed mask and reserved bits, and the unchanged flags and reconstructible pointers after pointer adjustments. A property cannot show the exact arithmetic values, the sign extension of negative immediates across the 16-bit boundary, or the cycle of delay on the registered flag path. Those come from the scoreboard's directed corner cases, such as 0x7F plus a carry-in, 0xFF plus 1 and a wrapping index, and from a long run of random operations checked against an independent model.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  typedef enum logic [2:0] {
    OP_ADC   = 3'd0,
    OP_ADD   = 3'd1,
    OP_AND   = 3'd2,
    OP_SHL   = 3'd3,
    OP_SHR   = 3'd4,
    OP_SPADJ = 3'd5,
    OP_HXADJ = 3'd6
  } alu_op_e;

  localparam int CCR_V = 7;
  localparam int CCR_H = 4;
  localparam int CCR_I = 3;
  localparam int CCR_N = 2;
  localparam int CCR_Z = 1;
  localparam int CCR_C = 0;
  localparam logic [7:0] CCR_FIXED = 8'h60;
  localparam logic [7:0] CCR_RST   = 8'h68;
endpackage

// File: rtl/alu_add8.sv
module alu_add8 #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          cin_i,
  output logic [DW-1:0] sum_o,
  output logic          c_o,
  output logic          h_o,
  output logic          v_o
);
  localparam int NIB = DW / 2;

  logic [DW:0]  full;
  logic [NIB:0] low;

  assign full  = {1'b0, a_i} + {1'b0, b_i} + {{DW{1'b0}}, cin_i};
  assign low   = {1'b0, a_i[NIB-1:0]} + {1'b0, b_i[NIB-1:0]} + {{NIB{1'b0}}, cin_i};
  assign sum_o = full[DW-1:0];
  assign c_o   = full[DW];
  assign h_o   = low[NIB];
  assign v_o   = (a_i[DW-1] ~^ b_i[DW-1]) & (full[DW-1] ^ a_i[DW-1]);

  // overflow equals carry into sign bit XOR carry out of it
  p_add_ovf_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v_o == ((a_i[DW-1] ^ b_i[DW-1] ^ sum_o[DW-1]) ^ c_o));
endmodule

// File: rtl/alu_shift8.sv
module alu_shift8 #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] a_i,
  input  logic          right_i,
  output logic [DW-1:0] res_o,
  output logic          c_o
);
  always_comb begin
    if (right_i) begin
      res_o = {a_i[DW-1], a_i[DW-1:1]};
      c_o   = a_i[0];
    end else begin
      res_o = {a_i[DW-2:0], 1'b0};
      c_o   = a_i[DW-1];
    end
  end

  p_shr_sign_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    right_i |-> (res_o[DW-1] == res_o[DW-2]));
  p_shl_lsb_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !right_i |-> (res_o[0] == 1'b0));
endmodule

// File: rtl/ptr_adj16.sv
module ptr_adj16 #(
  parameter int PW = 16,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [PW-1:0] base_i,
  input  logic [DW-1:0] imm_i,
  output logic [PW-1:0] res_o
);
  localparam int EXT = PW - DW;

  logic [PW-1:0] imm_sx;

  assign imm_sx = {{EXT{imm_i[DW-1]}}, imm_i};
  assign res_o  = base_i + imm_sx;

  // low byte must be recoverable by subtraction
  p_ptr_back_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_o[DW-1:0] - imm_i) == base_i[DW-1:0]);
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int DW      = 8,
  parameter int PW      = 16,
  parameter bit CCR_REG = 1'b0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [2:0]    op_i,
  input  logic [DW-1:0] acc_i,
  input  logic [DW-1:0] opnd_i,
  input  logic [7:0]    ccr_i,
  input  logic [PW-1:0] sp_i,
  input  logic [PW-1:0] hx_i,
  output logic [DW-1:0] res_o,
  output logic [PW-1:0] sp_o,
  output logic [PW-1:0] hx_o,
  output logic [7:0]    ccr_o
);
  alu_op_e op;
  assign op = alu_op_e'(op_i);

  logic [DW-1:0] add_sum, shf_res;
  logic          add_c, add_h, add_v, shf_c;
  logic [PW-1:0] sp_adj, hx_adj;
  logic [7:0]    ccr_nxt;
  logic          is_ptr;

  alu_add8 #(.DW(DW)) u_add (
    .clk_i, .rst_ni,
    .a_i   (acc_i),
    .b_i   (opnd_i),
    .cin_i (op == OP_ADC && ccr_i[CCR_C]),
    .sum_o (add_sum),
    .c_o   (add_c),
    .h_o   (add_h),
    .v_o   (add_v)
  );

  alu_shift8 #(.DW(DW)) u_shf (
    .clk_i, .rst_ni,
    .a_i     (acc_i),
    .right_i (op == OP_SHR),
    .res_o   (shf_res),
    .c_o     (shf_c)
  );

  ptr_adj16 #(.PW(PW), .DW(DW)) u_sp (
    .clk_i, .rst_ni, .base_i(sp_i), .imm_i(opnd_i), .res_o(sp_adj)
  );

  ptr_adj16 #(.PW(PW), .DW(DW)) u_hx (
    .clk_i, .rst_ni, .base_i(hx_i), .imm_i(opnd_i), .res_o(hx_adj)
  );

  assign is_ptr = (op == OP_SPADJ) || (op == OP_HXADJ);
  assign sp_o   = (op == OP_SPADJ) ? sp_adj : sp_i;
  assign hx_o   = (op == OP_HXADJ) ? hx_adj : hx_i;

  always_comb begin
    res_o   = acc_i;
    ccr_nxt = ccr_i | CCR_FIXED;
    unique case (op)
      OP_ADC, OP_ADD: begin
        res_o          = add_sum;
        ccr_nxt[CCR_V] = add_v;
        ccr_nxt[CCR_H] = add_h;
        ccr_nxt[CCR_C] = add_c;
      end
      OP_AND: begin
        res_o          = acc_i & opnd_i;
        ccr_nxt[CCR_V] = 1'b0;
      end
      OP_SHL, OP_SHR: begin
        res_o          = shf_res;
        ccr_nxt[CCR_C] = shf_c;
        ccr_nxt[CCR_V] = shf_res[DW-1] ^ shf_c;
      end
      default: ;
    endcase
    if (!is_ptr) begin
      ccr_nxt[CCR_N] = res_o[DW-1];
      ccr_nxt[CCR_Z] = (res_o == '0);
    end
  end

  generate
    if (CCR_REG) begin : g_ccr_q
      logic [7:0] ccr_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ccr_q <= CCR_RST;
        else         ccr_q <= ccr_nxt;
      end
      assign ccr_o = ccr_q;
    end else begin : g_ccr_c
      assign ccr_o = ccr_nxt;
    end
  endgenerate

  p_mask_kept_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ccr_nxt[CCR_I] == ccr_i[CCR_I]);
  p_fixed_ones_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ccr_nxt[6:5] == 2'b11);
  p_zero_flag_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !is_ptr |-> (ccr_nxt[CCR_Z] == (res_o == '0)));
  p_and_clr_v_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_AND) |-> !ccr_nxt[CCR_V]);
  p_shift_v_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_SHL || op == OP_SHR) |->
      (ccr_nxt[CCR_V] == (ccr_nxt[CCR_N] ^ ccr_nxt[CCR_C])));
  p_ptr_flags_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_ptr |-> ({ccr_nxt[7], ccr_nxt[4:0]} == {ccr_i[7], ccr_i[4:0]}) && (res_o == acc_i));
endmodule

// File: tb/sim_acc_alu.sv
`timescale 1ns/100ps
module sim_acc_alu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  op = '0;
  logic [7:0]  acc = '0, opnd = '0, ccr = '0;
  logic [15:0] sp = '0, hx = '0;
  logic [7:0]  res0, ccr0, res1, ccr1;
  logic [15:0] sp0, hx0, sp1, hx1;

  int checks = 0;
  int errors = 0;
  bit mon_on = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  acc_alu u0 (
    .clk_i(clk), .rst_ni(rst_n), .op_i(op), .acc_i(acc), .opnd_i(opnd),
    .ccr_i(ccr), .sp_i(sp), .hx_i(hx),
    .res_o(res0), .sp_o(sp0), .hx_o(hx0), .ccr_o(ccr0)
  );

  acc_alu #(.CCR_REG(1'b1)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .op_i(op), .acc_i(acc), .opnd_i(opnd),
    .ccr_i(ccr), .sp_i(sp), .hx_i(hx),
    .res_o(res1), .sp_o(sp1), .hx_o(hx1), .ccr_o(ccr1)
  );

  typedef struct {
    logic [2:0]  op;
    logic [7:0]  res;
    logic [7:0]  ccr;
    logic [15:0] sp;
    logic [15:0] hx;
  } item_t;

  item_t q[$];

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic item_t model(logic [2:0] o, logic [7:0] a, logic [7:0] m,
                                  logic [7:0] c, logic [15:0] s, logic [15:0] x);
    item_t it;
    int    sum, lo;
    logic  cin;
    it.op = o; it.res = a; it.ccr = c | 8'h60; it.sp = s; it.hx = x;
    case (o)
      3'd0, 3'd1: begin
        cin = (o == 3'd0) ? c[0] : 1'b0;
        sum = int'(a) + int'(m) + int'(cin);
        lo  = int'(a[3:0]) + int'(m[3:0]) + int'(cin);
        it.res    = sum[7:0];
        it.ccr[0] = sum > 255;
        it.ccr[4] = lo > 15;
        it.ccr[7] = ($signed(a) + $signed(m) + int'(cin) > 127) ||
                    ($signed(a) + $signed(m) + int'(cin) < -128);
      end
      3'd2: begin it.res = a & m; it.ccr[7] = 1'b0; end
      3'd3: begin it.res = a << 1; it.ccr[0] = a[7]; end
      3'd4: begin it.res = {a[7], a[7:1]}; it.ccr[0] = a[0]; end
      3'd5: it.sp = s + {{8{m[7]}}, m};
      default: it.hx = x + {{8{m[7]}}, m};
    endcase
    if (o <= 3'd4) begin
      it.ccr[2] = it.res[7];
      it.ccr[1] = (it.res == 8'h00);
      if (o >= 3'd3) it.ccr[7] = it.res[7] ^ it.ccr[0];
    end
    return it;
  endfunction

  task automatic drive(input logic [2:0] o, input logic [7:0] a, input logic [7:0] m,
                       input logic [7:0] c, input logic [15:0] s, input logic [15:0] x);
    @(negedge clk);
    op = o; acc = a; opnd = m; ccr = c; sp = s; hx = x;
    q.push_back(model(o, a, m, c, s, x));
  endtask

  // monitor: compare after each rising edge
  always @(posedge clk) begin
    if (mon_on && q.size() > 0) begin
      item_t e;
      #1;
      e = q.pop_front();
      case (e.op)
        3'd0: chk("R1 result", {8'h0, res0}, {8'h0, e.res});
        3'd1: chk("R2 result", {8'h0, res0}, {8'h0, e.res});
        3'd2: chk("R6 result", {8'h0, res0}, {8'h0, e.res});
        3'd3: chk("R7 result", {8'h0, res0}, {8'h0, e.res});
        3'd4: chk("R8 result", {8'h0, res0}, {8'h0, e.res});
        default: chk("R12 acc pass", {8'h0, res0}, {8'h0, e.res});
      endcase
      if (e.op <= 3'd1)      chk("R3 R4 R5 R13 flags", {8'h0, ccr0}, {8'h0, e.ccr});
      else if (e.op == 3'd2) chk("R5 R6 R13 flags", {8'h0, ccr0}, {8'h0, e.ccr});
      else if (e.op <= 3'd4) chk("R5 R9 R13 flags", {8'h0, ccr0}, {8'h0, e.ccr});
      else                   chk("R12 R13 flags", {8'h0, ccr0}, {8'h0, e.ccr});
      chk("R10 sp", sp0, e.sp);
      chk("R11 hx", hx0, e.hx);
      chk("R14 registered flags", {8'h0, ccr1}, {8'h0, e.ccr});
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R14 reset value", {8'h0, ccr1}, 16'h0068);
    @(negedge clk);
    rst_n = 1'b1;
    mon_on = 1'b1;
    drive(3'd0, 8'h7F, 8'h00, 8'h01, 16'h1000, 16'h2000); // R1 R3 R4: H,V,N
    drive(3'd1, 8'hFF, 8'h01, 8'h00, 16'h1000, 16'h2000); // R2 R3 R5: Z,C,H
    drive(3'd1, 8'h10, 8'h20, 8'h01, 16'h1000, 16'h2000); // R2: carry-in ignored
    drive(3'd0, 8'h80, 8'h80, 8'h00, 16'h1000, 16'h2000); // R4 negative overflow
    drive(3'd2, 8'hF0, 8'h0F, 8'h91, 16'h1000, 16'h2000); // R6 H,C kept, V cleared
    drive(3'd3, 8'h80, 8'h00, 8'h00, 16'h1000, 16'h2000); // R7 R9: Z,C,V
    drive(3'd4, 8'h81, 8'h00, 8'h18, 16'h1000, 16'h2000); // R8 R9 H kept
    drive(3'd5, 8'h55, 8'h80, 8'h9F, 16'h00FF, 16'h2000); // R10 negative imm
    drive(3'd6, 8'h55, 8'h01, 8'h08, 16'h1000, 16'hFFFF); // R11 wrap
    drive(3'd6, 8'h00, 8'hFF, 8'h00, 16'hABCD, 16'h0000); // R11 -1 borrow
    for (int i = 0; i < 400; i++)
      drive(3'($urandom_range(0, 6)), 8'($urandom), 8'($urandom), 8'($urandom),
            16'($urandom), 16'($urandom));
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule